// File: doc/BRIEF.md
# Multiplexed Segment LCD Timing Driver

This block generates the drive timing for a multiplexed segment LCD with up to four common lines and a parameterized number of segment lines. A single-cycle timebase pulse at 32768 Hz sets the pace. A clock select input picks one of four slot lengths, and a mode input picks static drive or two-, three- or four-way multiplexing with half or third bias. For every common and segment pin, the block outputs a 2-bit code that names the bias rail the analog pad should connect. It also outputs a frame strobe. The drive polarity flips on every frame so that no net DC reaches the glass.

Each segment has a 4-bit data word and a 4-bit blink mask. Bit n of each belongs to COM n. When global blink is enabled, a dot whose mask bit is set is shown as off during the off half of the blink period. The blink rate is either 1 Hz or 0.5 Hz. When the driver is disabled, every output is held at the ground code and the scan restarts cleanly. Mode and clock-select changes made while the driver runs are deferred to the next frame boundary.

Top module: `lcdSegDriver`

## Requirements
- R1: One time slot lasts 512, 256, 128 or 64 timebase ticks when `clkSel` is 0, 1, 2 or 3. After `enable` rises, slot 0 starts and the slot index advances after each such count of ticks.
- R2: `modeSel` selects the scheme. 0 gives four slots at third bias, 1 gives three slots at third bias, 2 gives two slots at half bias, 3 gives three slots at half bias, and 4 gives static drive (one slot). The codes 5 to 7 behave as static.
- R3: Level codes are 0 = ground, 1 = lower mid rail, 2 = upper mid rail, 3 = top rail. At half bias, code 1 is the single mid rail. The COM whose index equals the current slot is driven to 3 when polarity is 0 and to 0 when polarity is 1. Other used COMs are driven to 1 at half bias; at third bias they are driven to 1 when polarity is 0 and to 2 when polarity is 1. COMs whose index is at or above the slot count are driven to 0.
- R4: A segment's dot for the current slot is bit `slot` of its data word. A lit dot drives the SEG to 0 when polarity is 0 and to 3 when polarity is 1. An unlit dot drives the SEG to the following levels:
  - static drive: the selected COM's level;
  - half bias: 1;
  - third bias: 2 when polarity is 0 and 1 when polarity is 1.
- R5: Polarity is 0 in the first frame after enable and inverts at every frame boundary.
- R6: `frameStrobe` is high for exactly one clock, the cycle after the tick that ends the last slot of a frame.
- R7: A change of `modeSel` or `clkSel` while enabled takes effect at the next frame boundary. The current frame completes with the old settings.
- R8: While `enable` is low, all COM and SEG codes are 0 and `frameStrobe` is low. The next enable starts from slot 0 with polarity 0 and with the settings present while the driver was disabled.
- R9: The blink counter counts timebase ticks from reset. With `blinkSlow` at 0, the off half is when (ticks mod 32768) ≥ 16384. With `blinkSlow` at 1, the off half is when (ticks mod 65536) ≥ 32768. During the off half, with `blinkEn` high, a dot whose mask bit is 1 is shown as unlit.
- R10: Blink has no effect when `blinkEn` is low or when the dot's data bit is 0.
- R11: Clock cycles without a timebase tick advance neither the slot timing nor the blink counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at the 32768 Hz timebase rate |
| enable | input | 1 | Global driver enable |
| clkSel | input | 2 | Slot length select |
| modeSel | input | 3 | Multiplex and bias scheme |
| blinkEn | input | 1 | Global blink enable |
| blinkSlow | input | 1 | Blink rate: 0 = 1 Hz, 1 = 0.5 Hz |
| segData | input | NUM_SEG*4 | Per-segment dot words, bit n for COM n |
| blinkMask | input | NUM_SEG*4 | Per-segment blink masks, bit n for COM n |
| comLevel | output | 8 | Rail code for each of the four COM pins, COM n at bits 2n+1:2n |
| segLevel | output | NUM_SEG*2 | Rail code for each SEG pin, SEG s at bits 2s+1:2s |
| frameStrobe | output | 1 | One-clock pulse at each frame end |

## Verification
The assertions watch several properties on every cycle:
- the forced ground state while the driver is disabled;
- that the frame strobe is a single cycle and follows a tick;
- that no more than one COM ever sits on the top rail;
- that COM codes stay frozen across tickless cycles.

Other properties need the bench's scenarios, which compare every pin against an arithmetic model on every cycle:
- the exact slot lengths for each clock select;
- the slot count and bias for each mode;
- the polarity sequence across frames;
- the deferral of a live mode change to the frame boundary;
- the blink phases at both rates.

// File: rtl/lcdSegPkg.sv
package lcdSegPkg;

  localparam int NUM_COM = 4;
  localparam int LVL_W   = 2;
  localparam int SLOT_W  = 2;

  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } levelT;

  typedef enum logic [1:0] {
    BIAS_STATIC = 2'd0,
    BIAS_HALF   = 2'd1,
    BIAS_THIRD  = 2'd2
  } biasT;

  // Strobes and scan state handed from control to datapath each cycle.
  typedef struct packed {
    logic              active;
    logic              frameEnd;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] lastSlot;
    biasT              bias;
    logic              polarity;
    logic              blinkOff;
  } scanT;

  function automatic logic [SLOT_W-1:0] lastSlotForMode(input logic [2:0] mode);
    case (mode)
      3'b000:  return 2'd3;
      3'b001:  return 2'd2;
      3'b010:  return 2'd1;
      3'b011:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic biasT biasForMode(input logic [2:0] mode);
    case (mode)
      3'b000, 3'b001: return BIAS_THIRD;
      3'b010, 3'b011: return BIAS_HALF;
      default:        return BIAS_STATIC;
    endcase
  endfunction

endpackage

// File: rtl/lcdScanCtrl.sv
module lcdScanCtrl
  import lcdSegPkg::*;
#(
  parameter int PRE_W   = 9,
  parameter int SEL_W   = 2,
  parameter int BLINK_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             enable,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [2:0]       modeSel,
  input  logic             blinkSlow,
  output scanT             scan
);

  localparam logic [PRE_W-1:0] PRE_ALL  = '1;
  localparam int               FAST_BIT = BLINK_W - 2;
  localparam int               SLOW_BIT = BLINK_W - 1;

  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   preLast;
  logic [SLOT_W-1:0]  slotQ;
  logic [SLOT_W-1:0]  lastSlot;
  logic               polQ;
  logic               strobeQ;
  logic [2:0]         modeQ;
  logic [SEL_W-1:0]   clkSelQ;
  logic [BLINK_W-1:0] blinkCnt;
  logic               pinEvent;
  logic               frameWrap;

  // Slot length in ticks is 2^(PRE_W - clkSel); the last count is all-ones shifted down.
  assign preLast   = PRE_ALL >> clkSelQ;
  assign lastSlot  = lastSlotForMode(modeQ);
  assign pinEvent  = tick && (preCnt == preLast);
  assign frameWrap = pinEvent && (slotQ == lastSlot);

  // Free-running blink phase on the timebase (R9, R11).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkCnt <= '0;
    end else if (tick) begin
      blinkCnt <= blinkCnt + 1'b1;
    end
  end

  // Scan sequencing: prescaler, slot index, polarity, frame-boundary settings load.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      slotQ   <= '0;
      polQ    <= 1'b0;
      strobeQ <= 1'b0;
      modeQ   <= '0;
      clkSelQ <= '0;
    end else begin
      strobeQ <= 1'b0;
      if (!enable) begin
        preCnt  <= '0;
        slotQ   <= '0;
        polQ    <= 1'b0;
        modeQ   <= modeSel;
        clkSelQ <= clkSel;
      end else if (pinEvent) begin
        preCnt <= '0;
        if (frameWrap) begin
          slotQ   <= '0;
          polQ    <= ~polQ;
          strobeQ <= 1'b1;
          modeQ   <= modeSel;
          clkSelQ <= clkSel;
        end else begin
          slotQ <= slotQ + 1'b1;
        end
      end else if (tick) begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    scan.active   = enable;
    scan.frameEnd = strobeQ;
    scan.slot     = slotQ;
    scan.lastSlot = lastSlot;
    scan.bias     = biasForMode(modeQ);
    scan.polarity = polQ;
    scan.blinkOff = blinkSlow ? blinkCnt[SLOW_BIT] : blinkCnt[FAST_BIT];
  end

endmodule

// File: rtl/lcdLevelMap.sv
module lcdLevelMap
  import lcdSegPkg::*;
#(
  parameter int NUM_SEG = 8,
  localparam int DATA_W = NUM_SEG * NUM_COM
) (
  input  scanT                     scan,
  input  logic                     blinkEn,
  input  logic [DATA_W-1:0]        segData,
  input  logic [DATA_W-1:0]        blinkMask,
  output logic [NUM_COM*LVL_W-1:0] comLevel,
  output logic [NUM_SEG*LVL_W-1:0] segLevel,
  output logic                     frameStrobe
);

  function automatic levelT comDrive(input logic selected, input logic used, input scanT s);
    if (!s.active || !used) return LVL_GND;
    if (selected)           return s.polarity ? LVL_GND : LVL_TOP;
    if (s.bias == BIAS_THIRD) return s.polarity ? LVL_HIGH : LVL_LOW;
    return LVL_LOW;
  endfunction

  function automatic levelT segDrive(input logic dotOn, input scanT s);
    if (!s.active) return LVL_GND;
    if (dotOn)     return s.polarity ? LVL_TOP : LVL_GND;
    case (s.bias)
      BIAS_STATIC: return s.polarity ? LVL_GND : LVL_TOP;
      BIAS_THIRD:  return s.polarity ? LVL_LOW : LVL_HIGH;
      default:     return LVL_LOW;
    endcase
  endfunction

  assign frameStrobe = scan.frameEnd & scan.active;

  for (genvar c = 0; c < NUM_COM; c++) begin : gCom
    logic isSel;
    logic isUsed;
    assign isSel  = (scan.slot == SLOT_W'(c));
    assign isUsed = (SLOT_W'(c) <= scan.lastSlot);
    assign comLevel[c*LVL_W +: LVL_W] = comDrive(isSel, isUsed, scan);
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : gSeg
    logic [NUM_COM-1:0] word;
    logic [NUM_COM-1:0] mask;
    logic               dotOn;
    assign word  = segData[s*NUM_COM +: NUM_COM];
    assign mask  = blinkMask[s*NUM_COM +: NUM_COM];
    // A blinking dot is hidden only in the off half; unlit dots are unaffected (R9, R10).
    assign dotOn = word[scan.slot] & ~(blinkEn & mask[scan.slot] & scan.blinkOff);
    assign segLevel[s*LVL_W +: LVL_W] = segDrive(dotOn, scan);
  end

endmodule

// File: rtl/lcdSegDriver.sv
module lcdSegDriver
  import lcdSegPkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int PRE_W   = 9,
  parameter int BLINK_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic                   enable,
  input  logic [1:0]             clkSel,
  input  logic [2:0]             modeSel,
  input  logic                   blinkEn,
  input  logic                   blinkSlow,
  input  logic [NUM_SEG*4-1:0]   segData,
  input  logic [NUM_SEG*4-1:0]   blinkMask,
  output logic [7:0]             comLevel,
  output logic [NUM_SEG*2-1:0]   segLevel,
  output logic                   frameStrobe
);

  scanT scan;

  lcdScanCtrl #(
    .PRE_W  (PRE_W),
    .SEL_W  (2),
    .BLINK_W(BLINK_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .enable   (enable),
    .clkSel   (clkSel),
    .modeSel  (modeSel),
    .blinkSlow(blinkSlow),
    .scan     (scan)
  );

  lcdLevelMap #(
    .NUM_SEG(NUM_SEG)
  ) uMap (
    .scan       (scan),
    .blinkEn    (blinkEn),
    .segData    (segData),
    .blinkMask  (blinkMask),
    .comLevel   (comLevel),
    .segLevel   (segLevel),
    .frameStrobe(frameStrobe)
  );

endmodule

// File: rtl/lcdSegDriverChecks.sv
module lcdSegDriverChecks #(
  parameter int NUM_SEG = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tick,
  input logic                 enable,
  input logic [7:0]           comLevel,
  input logic [NUM_SEG*2-1:0] segLevel,
  input logic                 frameStrobe
);

  logic [3:0] comTop;
  for (genvar i = 0; i < 4; i++) begin : gTop
    assign comTop[i] = (comLevel[i*2 +: 2] == 2'd3);
  end

  assert_off_ground_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (comLevel == '0 && segLevel == '0 && !frameStrobe));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> !frameStrobe);

  assert_strobe_after_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |-> $past(tick));

  assert_one_com_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> $countones(comTop) <= 1);

  assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$past(tick)) |-> $stable(comLevel));

endmodule

bind lcdSegDriver lcdSegDriverChecks #(.NUM_SEG(NUM_SEG)) uChecks (
  .clk        (clk),
  .rstN       (rstN),
  .tick       (tick),
  .enable     (enable),
  .comLevel   (comLevel),
  .segLevel   (segLevel),
  .frameStrobe(frameStrobe)
);

// File: tb/lcdSegDriver_test.sv
module lcdSegDriver_test;

  localparam int NSEG = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tick = 1'b1;
  logic              enable = 1'b0;
  logic [1:0]        clkSel = 2'd0;
  logic [2:0]        modeSel = 3'd0;
  logic              blinkEn = 1'b0;
  logic              blinkSlow = 1'b0;
  logic [NSEG*4-1:0] segData = '0;
  logic [NSEG*4-1:0] blinkMask = '0;
  logic [7:0]        comLevel;
  logic [NSEG*2-1:0] segLevel;
  logic              frameStrobe;

  lcdSegDriver #(.NUM_SEG(NSEG)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .clkSel(clkSel),
    .modeSel(modeSel), .blinkEn(blinkEn), .blinkSlow(blinkSlow),
    .segData(segData), .blinkMask(blinkMask), .comLevel(comLevel),
    .segLevel(segLevel), .frameStrobe(frameStrobe)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  string scen = "R8 reset";

  // Arithmetic model state.
  int j = 0, k = 0, baseK = 0, basePol = 0, mMode = 0, mSel = 0;
  int pendK = 0, pendMode = 0, pendSel = 0;
  bit pendValid = 0, kStep = 0;

  function automatic int slotsOf(int m);
    case (m)
      0: return 4;
      1: return 3;
      2: return 2;
      3: return 3;
      default: return 1;
    endcase
  endfunction

  // 0 static, 1 half, 2 third
  function automatic int biasOf(int m);
    if (m <= 1) return 2;
    if (m <= 3) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) j = 0;
    else if (tick) j = j + 1;
    kStep = 0;
    if (!rstN || !enable) begin
      k = 0; baseK = 0; basePol = 0;
      mMode = int'(modeSel); mSel = int'(clkSel); pendValid = 0;
    end else if (tick) begin
      k = k + 1; kStep = 1;
    end
  end

  task automatic report(string req, string what, int act, int exp);
    fails++;
    if (fails <= 30)
      $display("FAIL %s [%s] %s actual=%0d expected=%0d at %0t", req, scen, what, act, exp, $time);
  endtask

  always @(negedge clk) begin
    int s, dv, fl, kk, slot, pol, bias, expC, expS;
    bit off, expStr, dot, blk, bad;
    bad = 0;
    s = slotsOf(mMode); dv = 512 >> mSel; fl = dv * s; kk = k - baseK;
    expStr = enable && rstN && kStep && kk > 0 && (kk % fl == 0);
    if (enable && rstN && pendValid && k == pendK) begin
      basePol = basePol ^ ((kk / fl) & 1);
      baseK = k; mMode = pendMode; mSel = pendSel; pendValid = 0;
      s = slotsOf(mMode); dv = 512 >> mSel; fl = dv * s; kk = 0;
    end
    slot = (kk / dv) % s;
    pol = basePol ^ ((kk / fl) & 1);
    bias = biasOf(mMode);
    off = blinkSlow ? j[15] : j[14];
    checks++;
    if (frameStrobe !== expStr) begin
      report("R6", "frameStrobe", int'(frameStrobe), int'(expStr)); bad = 1;
    end
    for (int c = 0; c < 4 && !bad; c++) begin
      if (!enable) expC = 0;
      else if (c >= s) expC = 0;
      else if (c == slot) expC = pol ? 0 : 3;
      else if (bias == 2) expC = pol ? 2 : 1;
      else expC = 1;
      if (int'(comLevel[c*2 +: 2]) != expC) begin
        report(enable ? "R3" : "R8", $sformatf("com%0d", c), int'(comLevel[c*2 +: 2]), expC);
        bad = 1;
      end
    end
    for (int g = 0; g < NSEG && !bad; g++) begin
      blk = blinkEn && blinkMask[g*4 + slot] && off;
      dot = segData[g*4 + slot] && !blk;
      if (!enable) expS = 0;
      else if (dot) expS = pol ? 3 : 0;
      else if (bias == 0) expS = pol ? 0 : 3;
      else if (bias == 2) expS = pol ? 1 : 2;
      else expS = 1;
      if (int'(segLevel[g*2 +: 2]) != expS) begin
        report(!enable ? "R8" : (blk ? "R9" : "R4"), $sformatf("seg%0d", g),
               int'(segLevel[g*2 +: 2]), expS);
        bad = 1;
      end
    end
  end

  task automatic adv(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Change settings while running; the model defers them to the next frame end (R7).
  task automatic liveCfg(int m, int c);
    int fl;
    fl = slotsOf(mMode) * (512 >> mSel);
    modeSel = 3'(m); clkSel = 2'(c);
    pendK = baseK + (((k - baseK) / fl) + 1) * fl;
    pendMode = m; pendSel = c; pendValid = 1;
  endtask

  task automatic runCfg(int m, int c, int frames);
    int fl;
    enable = 0; modeSel = 3'(m); clkSel = 2'(c);
    adv(2);
    enable = 1;
    fl = slotsOf(m) * (512 >> c);
    for (int f = 0; f < frames * 2; f++) begin
      segData = $urandom;
      adv(fl / 2);
    end
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    adv(3);
    rstN = 1;                   // R8: outputs ground while disabled
    adv(4);
    // R1 R2 R3 R4 R5 R6: every mode at every slot length, two frames each
    scen = "R1 R2 R5 sweep";
    for (int m = 0; m <= 4; m++)
      for (int c = 0; c < 4; c++)
        runCfg(m, c, 2);
    scen = "R2 reserved modes";
    for (int m = 5; m <= 7; m++) runCfg(m, 3, 2);
    // R7: live change mid-frame
    scen = "R7 live change";
    runCfg(0, 3, 1);
    adv(100);
    liveCfg(2, 2);
    adv(700);
    liveCfg(4, 3);
    adv(400);
    liveCfg(1, 3);
    adv(600);
    // R8: disable mid-frame, then resume from slot 0
    scen = "R8 disable";
    enable = 0; adv(50);
    enable = 1; adv(300);
    // R11: irregular timebase
    scen = "R11 tick gaps";
    runCfg(1, 3, 0);
    for (int i = 0; i < 900; i++) begin
      tick = (i % 3) != 0;
      adv(1);
    end
    tick = 1;
    // R9 R10: blink at 1 Hz, then 0.5 Hz, with blink enable toggled
    scen = "R9 R10 blink fast";
    runCfg(0, 3, 0);
    blinkSlow = 0;
    for (int i = 0; i < 8; i++) begin
      blinkEn = (i % 4) != 3;
      segData = $urandom; blinkMask = $urandom;
      adv(5000);
    end
    scen = "R9 R10 blink slow";
    blinkSlow = 1;
    for (int i = 0; i < 14; i++) begin
      blinkEn = (i % 5) != 2;
      segData = $urandom; blinkMask = $urandom;
      adv(5000);
    end
    scen = "R8 final";
    enable = 0; adv(20);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule